// File: doc/BRIEF.md
# PHY Management Access Controller

This block lets a processor reach the registers of up to 32 external PHYs over a two-wire serial management bus made of a clock line (MDC) and a bidirectional data line (MDIO). Software fills four 32-bit control words: a target mask for writes, a command word, a data word and an extended-address word. It then sets the start flag in the command word. The unit builds the serial frames, shifts them out, collects read data from the PHY and clears the start flag when it has finished.

Two access styles share the one start flag. A paged access first selects a page by writing register 31 of the PHY and then reads or writes the target register. An extended (MMD) access sends an address frame that carries the device and the register address, then a data frame that reads or writes. A write command goes to every PHY whose mask bit is set, in ascending address order. A read command goes to the single PHY named in the data word, and the result returns in the low half of that word. The command word is kept apart from the start flag when a command completes, so fields that software parks there remain in place.

The serial clock comes from the system clock through a divider that software sets. MDC idles low between frames.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, all four control words read as zero, `mdc` is low and `mdioOe` is low.
- R2: Bit 0 of the command word (address 1) reads as 1 from the start write until the command finishes, then clears. Completion changes no other bit of the command word, including park bits 19:15 and the mode bit 1.
- R3: Every frame starts with 32 driven ones. A paged frame continues with start code 01, then opcode 10 for a read or 01 for a write. An MMD frame continues with start code 00, then opcode 00 for an address, 01 for a write or 11 for a read. Next come a 5-bit PHY address, a 5-bit register or device field, turnaround 10 and 16 data bits, all sent MSB first.
- R4: With command bit 1 = 0 (paged), each PHY first receives a write to register 31 with data {4'b0, cmd[14:3]}. It then receives the target access to register cmd[24:20].
- R5: With command bit 1 = 1 (MMD), each PHY first receives an address frame with device ext[20:16] and data ext[15:0] (address 3). It then receives a read or write frame to the same device.
- R6: With command bit 2 = 1 (write), the frame pair goes to each PHY whose bit is set in the mask word (address 0), in ascending order, with write data taken from data[31:16] (address 2). An all-zero mask sends no frame and the command still completes.
- R7: With command bit 2 = 0 (read), the target is the PHY given by data[20:16]. The 16 bits received are stored in data[15:0] on completion, and data[31:16] is left unchanged.
- R8: During the two turnaround bits and the 16 data bits of a read frame, `mdioOe` is low. Read data is sampled on rising MDC edges.
- R9: Each half period of MDC lasts `divCfg`+1 system clocks. `mdioOut` changes only on falling MDC edges while driven. MDC rests low between frames.
- R10: Writes to any control word are ignored while the start flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regAddr | input | 2 | Control word select: 0 mask, 1 command, 2 data, 3 extended address |
| regWrData | input | 32 | Control word write value |
| regRdData | output | 32 | Selected control word (combinational) |
| divCfg | input | 8 | MDC half period minus one, in system clocks |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO drive value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO line as seen at the pad |

## Verification
The bench puts both mask edges (PHY 0 and PHY 31) into one write and sends a write with an empty mask. A design that scanned the mask off by one, or that stalled on an empty mask, would leave expected frames unmatched or never clear the start flag. A paged access at page 4095 and register 31 catches page or register fields that are cut short. Comparing every frame, including its preamble, against a scoreboard exposes swapped opcodes, a missing page-select frame or a missing MMD address frame. Read-backs of the command and data words after each command catch park bits lost at completion, a PHY address overwritten by read data, or a write accepted while busy. A model PHY that drives data only after the turnaround catches both a controller that keeps driving the line and one that samples on the wrong edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef struct packed {
    logic        load;
    logic        rdFrame;
    logic [31:0] word;
  } mdioCmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_ISSUE, ST_WAIT} seqState_t;
endpackage

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int NUM_PHY = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        frameDone,
  input  logic [15:0] rdWord,
  output mdioCmd_t    cmd
);
  localparam int PORT_W = $clog2(NUM_PHY);

  logic [31:0] maskR, ctl1R, dataR, extR;
  seqState_t   st;
  logic [PORT_W-1:0] portIdx;
  logic        phase;
  logic        isWr, isMmd, lastPort;
  logic [4:0]  phyF;
  logic [15:0] wrVal;

  assign isWr     = ctl1R[2];
  assign isMmd    = ctl1R[1];
  assign lastPort = (portIdx == PORT_W'(NUM_PHY - 1));
  assign phyF     = 5'(portIdx);
  assign wrVal    = isWr ? dataR[31:16] : 16'h0000;

  // frame word after the preamble: start, opcode, phy, reg/dev, turnaround, data
  always_comb begin
    cmd.load    = (st == ST_ISSUE);
    cmd.rdFrame = !isWr && phase;
    if (isMmd) begin
      if (phase) cmd.word = {2'b00, (isWr ? 2'b01 : 2'b11), phyF, extR[20:16], 2'b10, wrVal};
      else       cmd.word = {2'b00, 2'b00, phyF, extR[20:16], 2'b10, extR[15:0]};
    end else begin
      if (phase) cmd.word = {2'b01, (isWr ? 2'b01 : 2'b10), phyF, ctl1R[24:20], 2'b10, wrVal};
      else       cmd.word = {2'b01, 2'b01, phyF, 5'd31, 2'b10, 4'b0000, ctl1R[14:3]};
    end
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = maskR;
      2'd1:    regRdData = ctl1R;
      2'd2:    regRdData = dataR;
      default: regRdData = extR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskR   <= '0;
      ctl1R   <= '0;
      dataR   <= '0;
      extR    <= '0;
      st      <= ST_IDLE;
      portIdx <= '0;
      phase   <= 1'b0;
    end else begin
      if (regWrEn && !ctl1R[0]) begin
        case (regAddr)
          2'd0:    maskR <= regWrData;
          2'd1:    ctl1R <= regWrData;
          2'd2:    dataR <= regWrData;
          default: extR  <= regWrData;
        endcase
      end
      case (st)
        ST_IDLE: if (ctl1R[0]) begin
          phase <= 1'b0;
          if (isWr) begin
            portIdx <= '0;
            st      <= ST_SEEK;
          end else begin
            portIdx <= dataR[16 +: PORT_W];
            st      <= ST_ISSUE;
          end
        end
        ST_SEEK: begin
          if (maskR[portIdx]) st <= ST_ISSUE;
          else if (lastPort) begin
            ctl1R[0] <= 1'b0;
            st       <= ST_IDLE;
          end else portIdx <= portIdx + 1'b1;
        end
        ST_ISSUE: st <= ST_WAIT;
        default: if (frameDone) begin
          if (!phase) begin
            phase <= 1'b1;
            st    <= ST_ISSUE;
          end else begin
            phase <= 1'b0;
            if (!isWr) begin
              dataR[15:0] <= rdWord;
              ctl1R[0]    <= 1'b0;
              st          <= ST_IDLE;
            end else if (lastPort) begin
              ctl1R[0] <= 1'b0;
              st       <= ST_IDLE;
            end else begin
              portIdx <= portIdx + 1'b1;
              st      <= ST_SEEK;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divCfg,
  input  mdioCmd_t         cmd,
  output logic             frameDone,
  output logic [15:0]      rdWord,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int TA_POS    = PRE_LEN + 14;
  localparam int DATA_POS  = PRE_LEN + 16;

  logic                 busy, rdFrameR;
  logic [DIV_W-1:0]     divCnt;
  logic [CNT_W-1:0]     bitCnt;
  logic [FRAME_LEN-1:0] shiftR;
  logic                 tick, riseTick, fallTick;

  assign tick     = busy && (divCnt == divCfg);
  assign riseTick = tick && !mdc;
  assign fallTick = tick && mdc;
  assign mdioOut  = busy && shiftR[FRAME_LEN-1];
  assign mdioOe   = busy && !(rdFrameR && bitCnt >= CNT_W'(TA_POS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      rdFrameR  <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      shiftR    <= '0;
      mdc       <= 1'b0;
      frameDone <= 1'b0;
      rdWord    <= '0;
    end else begin
      frameDone <= 1'b0;
      if (!busy) begin
        if (cmd.load) begin
          busy     <= 1'b1;
          rdFrameR <= cmd.rdFrame;
          divCnt   <= '0;
          bitCnt   <= '0;
          mdc      <= 1'b0;
          shiftR   <= {{PRE_LEN{1'b1}}, cmd.word};
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) mdc <= !mdc;
        if (riseTick && rdFrameR && bitCnt >= CNT_W'(DATA_POS))
          rdWord <= {rdWord[14:0], mdioIn};
        if (fallTick) begin
          shiftR <= {shiftR[FRAME_LEN-2:0], 1'b0};
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(FRAME_LEN - 1)) begin
            busy      <= 1'b0;
            frameDone <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int NUM_PHY = 32,
  parameter int PRE_LEN = 32,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [DIV_W-1:0] divCfg,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  mdioCmd_t    cmd;
  logic        frameDone;
  logic [15:0] rdWord;

  mdio_seq #(.NUM_PHY(NUM_PHY)) i_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .frameDone(frameDone), .rdWord(rdWord), .cmd(cmd)
  );

  mdio_shift #(.PRE_LEN(PRE_LEN), .DIV_W(DIV_W)) i_shift (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .cmd(cmd),
    .frameDone(frameDone), .rdWord(rdWord),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk,
  input logic rstN,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic cmdLoad,
  input logic frameDone
);
  // R9
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && $past(mdioOe) && (mdioOut != $past(mdioOut))) |-> $fell(mdc));
  // R9
  idle_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!mdc && !mdioOe));
  // R8
  load_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |-> !mdioOe);
  // R3
  preamble_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |=> (mdioOe && mdioOut));
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !cmdLoad);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk i_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .cmdLoad(cmd.load), .frameDone(frameDone)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  divCfg = 8'd1;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0, nFails = 0, nFrames = 0;
  logic [32:0] expQ[$];
  longint cyc = 0, lastRise = 0, lastPeriod = 0;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .divCfg(divCfg),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---- driver side: expected frames ----
  task automatic expFrame(input bit rd, input logic [1:0] stc, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    expQ.push_back({rd, stc, op, phy, rg, 2'b10, d});
  endtask

  // ---- model PHY and monitor ----
  logic [63:0] fbits;
  int          pos = 0;
  bit          rdF = 0, oeBad = 0;
  logic [15:0] rv, prevData = '0;

  function automatic logic [15:0] modelVal(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] prev);
    return {phy, rg, 6'b0} ^ prev;
  endfunction

  always @(posedge mdc) begin
    logic line;
    logic [32:0] e;
    line = mdioOe ? mdioOut : mdioIn;
    if (pos > 0) lastPeriod = cyc - lastRise;
    lastRise = cyc;
    if (rdF && pos >= 46 && mdioOe) oeBad = 1;
    fbits[63-pos] = line;
    pos++;
    if (pos == 46) begin
      rdF = (fbits[31:30] == 2'b01 && fbits[29:28] == 2'b10) ||
            (fbits[31:30] == 2'b00 && fbits[29:28] == 2'b11);
      rv  = modelVal(fbits[27:23], fbits[22:18], prevData);
    end
    if (pos == 64) begin
      nFrames++;
      check(fbits[63:32] == 32'hFFFF_FFFF, "R3 preamble", fbits[63:32], 32'hFFFF_FFFF);
      if (expQ.size() == 0) check(0, "R3 unexpected frame", fbits[31:0], 0);
      else begin
        e = expQ.pop_front();
        if (e[32]) begin
          check(fbits[31:18] == e[31:18], "R3 read frame header", fbits[31:18], e[31:18]);
          check(!oeBad, "R8 line released in read", oeBad, 0);
        end else
          check(fbits[31:0] == e[31:0], "R3 frame", fbits[31:0], e[31:0]);
      end
      if (!rdF) prevData = fbits[15:0];
      pos = 0; rdF = 0; oeBad = 0;
    end
  end

  always @(negedge mdc) begin
    if (rdF && pos >= 48 && pos <= 63) mdioIn = rv[63-pos];
    else mdioIn = 1'b1;
  end

  // ---- register access ----
  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone();
    logic [31:0] v;
    v = 32'h1;
    while (v[0]) regRead(2'd1, v);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mkCmd(input logic [4:0] rg, input logic [4:0] park,
                                        input logic [11:0] page, input bit wr, input bit mmd);
    return {7'b0, rg, park, page, wr, mmd, 1'b1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v, c1;
    int fr;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v);
      check(v == 0, "R1 reset word", v, 0);
    end
    check(!mdc && !mdioOe, "R1 mdc/oe idle", {mdc, mdioOe}, 0);

    // T2: paged write to PHYs 3 and 17, slow divider (R4, R6, R9, R2, R10)
    divCfg = 8'd3;
    regWrite(2'd0, (32'h1 << 3) | (32'h1 << 17));
    regWrite(2'd2, 32'hA55A_0000);
    c1 = mkCmd(5'd4, 5'h0A, 12'h02B, 1, 0);
    expFrame(0, 2'b01, 2'b01, 5'd3, 5'd31, 16'h002B);
    expFrame(0, 2'b01, 2'b01, 5'd3, 5'd4, 16'hA55A);
    expFrame(0, 2'b01, 2'b01, 5'd17, 5'd31, 16'h002B);
    expFrame(0, 2'b01, 2'b01, 5'd17, 5'd4, 16'hA55A);
    regWrite(2'd1, c1);
    repeat (50) @(negedge clk);
    regRead(2'd1, v);
    check(v[0] == 1'b1, "R2 start flag held while busy", v[0], 1);
    regWrite(2'd2, 32'h1234_5678);   // R10: must be ignored
    regWrite(2'd1, 32'h0);           // R10: must be ignored
    waitDone();
    check(expQ.size() == 0, "R6 all mask frames seen", expQ.size(), 0);
    regRead(2'd2, v);
    check(v == 32'hA55A_0000, "R10 write ignored while busy", v, 32'hA55A_0000);
    regRead(2'd1, v);
    check(v == (c1 & ~32'h1), "R2 command bits kept", v, c1 & ~32'h1);
    check(lastPeriod == 8, "R9 mdc period divCfg=3", lastPeriod, 8);
    check(!mdc, "R9 mdc low when idle", mdc, 0);

    // T3: paged read of PHY 9, page 0x123, register 5 (R4, R7, R2)
    divCfg = 8'd1;
    regWrite(2'd2, 32'h0009_0000);
    c1 = mkCmd(5'd5, 5'h15, 12'h123, 0, 0);
    expFrame(0, 2'b01, 2'b01, 5'd9, 5'd31, 16'h0123);
    expFrame(1, 2'b01, 2'b10, 5'd9, 5'd5, 16'h0);
    regWrite(2'd1, c1);
    waitDone();
    check(expQ.size() == 0, "R4 paged read frames", expQ.size(), 0);
    regRead(2'd2, v);
    check(v == {16'h0009, modelVal(5'd9, 5'd5, 16'h0123)}, "R7 paged read result",
          v, {16'h0009, modelVal(5'd9, 5'd5, 16'h0123)});
    regRead(2'd1, v);
    check(v == (c1 & ~32'h1), "R2 park bits kept after read", v, c1 & ~32'h1);
    check(lastPeriod == 4, "R9 mdc period divCfg=1", lastPeriod, 4);

    // T4: MMD write to PHYs 0 and 31 (R5, R6 mask edges)
    regWrite(2'd0, 32'h8000_0001);
    regWrite(2'd2, 32'hCAFE_0000);
    regWrite(2'd3, {11'b0, 5'd3, 16'h1234});
    expFrame(0, 2'b00, 2'b00, 5'd0, 5'd3, 16'h1234);
    expFrame(0, 2'b00, 2'b01, 5'd0, 5'd3, 16'hCAFE);
    expFrame(0, 2'b00, 2'b00, 5'd31, 5'd3, 16'h1234);
    expFrame(0, 2'b00, 2'b01, 5'd31, 5'd3, 16'hCAFE);
    regWrite(2'd1, mkCmd(5'd0, 5'd0, 12'h0, 1, 1));
    waitDone();
    check(expQ.size() == 0, "R5 MMD write frames", expQ.size(), 0);

    // T5: MMD read of PHY 30, device 7, register 0xBEEF (R5, R7, R8)
    regWrite(2'd2, 32'h001E_0000);
    regWrite(2'd3, {11'b0, 5'd7, 16'hBEEF});
    expFrame(0, 2'b00, 2'b00, 5'd30, 5'd7, 16'hBEEF);
    expFrame(1, 2'b00, 2'b11, 5'd30, 5'd7, 16'h0);
    regWrite(2'd1, mkCmd(5'd0, 5'd0, 12'h0, 0, 1));
    waitDone();
    check(expQ.size() == 0, "R5 MMD read frames", expQ.size(), 0);
    regRead(2'd2, v);
    check(v == {16'h001E, modelVal(5'd30, 5'd7, 16'hBEEF)}, "R7 MMD read result",
          v, {16'h001E, modelVal(5'd30, 5'd7, 16'hBEEF)});

    // T6: boundary page 4095, register 31, fastest divider (R4, R9)
    divCfg = 8'd0;
    regWrite(2'd0, 32'h1);
    regWrite(2'd2, 32'h0F0F_0000);
    expFrame(0, 2'b01, 2'b01, 5'd0, 5'd31, 16'h0FFF);
    expFrame(0, 2'b01, 2'b01, 5'd0, 5'd31, 16'h0F0F);
    regWrite(2'd1, mkCmd(5'd31, 5'd0, 12'hFFF, 1, 0));
    waitDone();
    check(expQ.size() == 0, "R4 page 4095 register 31", expQ.size(), 0);
    check(lastPeriod == 2, "R9 mdc period divCfg=0", lastPeriod, 2);

    // T7: empty mask write completes with no frames (R6)
    fr = nFrames;
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, mkCmd(5'd2, 5'd0, 12'h0, 1, 0));
    waitDone();
    check(nFrames == fr, "R6 empty mask sends nothing", nFrames, fr);
    regRead(2'd1, v);
    check(v[0] == 1'b0, "R6 empty mask completes", v[0], 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule